// File: doc/BRIEF.md
# Survivor History Store with Merge Release

This block keeps the decided information bits of K survivor paths for a tree-search detector-decoder that stacks many channel realizations, each covering M tree levels. Within a realization, a bank of K registers holds each survivor's bit list. At every level the upstream sorter reports, for each new rank, which old rank it grew from and the bit it decided. When a realization closes, the K bit lists are written as one line of a circular line memory. Beside each line, a pointer memory records, for every rank, the rank in the previous line it descends from.

After each line write a walker follows the pointer chains back from the newest line to the oldest held line. If every current survivor leads to one common ancestor there, that oldest line is settled and is released at once along that ancestor. The walk then repeats for the next line. The line memory can therefore be much shorter than the codeword. If the memory fills without a merge, the oldest line is forced out along the ancestry of the rank-0 survivor and a flag marks it. On the last level of the codeword, the chain from the chosen best survivor is followed and every remaining line is released, oldest first.

Top module: `shr_survivor_store`

## Requirements
- R1: On each accepted level step, survivor i's bit list becomes the list of its reported parent rank, shifted by one place, with survivor i's new bit in the lowest place. A released word therefore holds the first level of its realization in its most significant bit and the last level in bit 0.
- R2: Every M-th accepted step closes a line. For each rank, the line records the rank in the previous line that it descends from, composed over all M levels of the realization. Traceback follows these records.
- R3: After a line is written, if all current survivors descend from one rank of the oldest held line, that line is output along that rank with out_ovf low. Younger lines are then checked in the same way.
- R4: While fewer than DEPTH lines are held and the survivors have no common ancestor in the oldest line, no word is output.
- R5: When DEPTH lines are held after a write and no merge exists, the oldest line is output along the ancestry of the rank-0 survivor, with out_ovf high in the same cycle as out_valid.
- R6: A step with step_last high ends the codeword. All held lines are then output oldest first along the ancestry of step_best, and out_done is high together with the final word.
- R7: stall is high from the cycle after a line is written until the walk for that line ends. Steps presented while stall is high are not accepted.
- R8: After reset, out_valid, out_ovf, out_done and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | One tree level's survivor update is presented |
| step_par | input | K*RW | Parent rank of each new rank; rank i in bits [i*RW +: RW] |
| step_bit | input | K | Decided bit of each new rank |
| step_last | input | 1 | This step closes the final realization of the codeword |
| step_best | input | RW | Rank of the best survivor, used with step_last |
| stall | output | 1 | Walker busy; steps are not accepted |
| out_valid | output | 1 | A released line word is on out_bits |
| out_bits | output | M | Bits of one realization along the chosen path |
| out_ovf | output | 1 | The word was forced out without a merge |
| out_done | output | 1 | Final word of the codeword |

## Verification
The bench builds the block with K = 4, M = 4 and DEPTH = 4. With a four-line memory, the forced release is reached after only four unmerged realizations, and a six-realization codeword exercises early release, forced release and end traceback within a few hundred cycles. The bench uses rank orders that reverse inside a realization and parent pointers that rotate across realizations. This checks that bits follow the parent lists and that traceback follows the stored chains rather than the rank positions.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    W_IDLE,
    W_CHK,
    W_APPLY,
    W_HEAD
  } walk_e;
endpackage

// File: rtl/shr_lmem.sv
// Simple dual-port line memory with registered read (block RAM style).
module shr_lmem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/shr_bank.sv
// Per-rank bit lists of the current realization plus ancestry in the previous line.
module shr_bank #(
  parameter int K  = 8,
  parameter int M  = 8,
  parameter int RW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           first,
  input  logic [K*RW-1:0] par,
  input  logic [K-1:0]   bits,
  output logic [K*M-1:0] nxt_bits,
  output logic [K*RW-1:0] nxt_orig
);
  logic [M-1:0]  bank [K];
  logic [RW-1:0] orig [K];

  always_comb begin
    for (int i = 0; i < K; i++) begin
      nxt_bits[i*M +: M]   = {bank[par[i*RW +: RW]][M-2:0], bits[i]};
      nxt_orig[i*RW +: RW] = first ? par[i*RW +: RW] : orig[par[i*RW +: RW]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) begin
        bank[i] <= '0;
        orig[i] <= '0;
      end
    end else if (step) begin
      for (int i = 0; i < K; i++) begin
        bank[i] <= nxt_bits[i*M +: M];
        orig[i] <= nxt_orig[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/shr_survivor_store.sv
// K, M >= 2 and DEPTH powers of two.
module shr_survivor_store #(
  parameter int K     = 8,
  parameter int M     = 8,
  parameter int DEPTH = 16,
  localparam int RW   = $clog2(K),
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(M)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_valid,
  input  logic [K*RW-1:0] step_par,
  input  logic [K-1:0]    step_bit,
  input  logic            step_last,
  input  logic [RW-1:0]   step_best,
  output logic            stall,
  output logic            out_valid,
  output logic [M-1:0]    out_bits,
  output logic            out_ovf,
  output logic            out_done
);
  import shr_pkg::*;

  walk_e          st;
  logic [LW-1:0]  lvl;
  logic [AW-1:0]  wr_ptr, head, cur;
  logic [CW-1:0]  cnt;
  logic           flush;
  logic [RW-1:0]  best;
  logic [RW-1:0]  v [K];
  logic           accept, line_we, merged;
  logic [K*M-1:0]  nxt_bits, bits_rd;
  logic [K*RW-1:0] nxt_orig, ptr_rd;

  assign stall   = (st != W_IDLE);
  assign accept  = step_valid && (st == W_IDLE);
  assign line_we = accept && (lvl == LW'(M - 1));

  shr_bank #(.K(K), .M(M), .RW(RW)) u_bank (
    .clk(clk), .rst(rst), .step(accept), .first(lvl == '0),
    .par(step_par), .bits(step_bit), .nxt_bits(nxt_bits), .nxt_orig(nxt_orig)
  );

  shr_lmem #(.W(K*M), .DEPTH(DEPTH)) u_bits_mem (
    .clk(clk), .we(line_we), .waddr(wr_ptr), .wdata(nxt_bits),
    .raddr(head), .rdata(bits_rd)
  );

  shr_lmem #(.W(K*RW), .DEPTH(DEPTH)) u_ptr_mem (
    .clk(clk), .we(line_we), .waddr(wr_ptr), .wdata(nxt_orig),
    .raddr(cur), .rdata(ptr_rd)
  );

  always_comb begin
    merged = 1'b1;
    for (int i = 1; i < K; i++)
      if (v[i] != v[0]) merged = 1'b0;
    if (flush) merged = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      lvl       <= '0;
      wr_ptr    <= '0;
      head      <= '0;
      cur       <= '0;
      cnt       <= '0;
      flush     <= 1'b0;
      best      <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_ovf   <= 1'b0;
      out_done  <= 1'b0;
      for (int i = 0; i < K; i++) v[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
      out_done  <= 1'b0;
      if (accept) lvl <= (lvl == LW'(M - 1)) ? '0 : lvl + 1'b1;
      case (st)
        W_IDLE: begin
          if (line_we) begin
            wr_ptr <= wr_ptr + 1'b1;
            cnt    <= cnt + 1'b1;
            cur    <= wr_ptr;
            flush  <= step_last;
            best   <= step_best;
            for (int i = 0; i < K; i++) v[i] <= step_last ? step_best : RW'(i);
            st     <= W_CHK;
          end
        end
        W_CHK: st <= (cur == head) ? W_HEAD : W_APPLY;
        W_APPLY: begin
          for (int i = 0; i < K; i++) v[i] <= ptr_rd[int'(v[i])*RW +: RW];
          cur <= cur - 1'b1;
          st  <= W_CHK;
        end
        W_HEAD: begin
          if (merged || cnt == CW'(DEPTH)) begin
            out_valid <= 1'b1;
            out_bits  <= bits_rd[int'(v[0])*M +: M];
            out_ovf   <= !merged;
            head      <= head + 1'b1;
            cnt       <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              out_done <= flush;
              flush    <= 1'b0;
              st       <= W_IDLE;
            end else begin
              cur <= wr_ptr - 1'b1;
              for (int i = 0; i < K; i++) v[i] <= flush ? best : RW'(i);
              st  <= W_CHK;
            end
          end else begin
            st <= W_IDLE;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shr_survivor_store_chk.sv
module shr_survivor_store_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          out_valid,
  input logic          out_ovf,
  input logic          out_done,
  input logic          line_we,
  input logic [CW-1:0] cnt
);
  a_r5_ovf_with_word: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> out_valid);

  a_r6_done_with_word: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_valid);

  a_r7_stall_after_line: assert property (@(posedge clk) disable iff (rst)
    line_we |=> stall);

  a_r3_release_from_walk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(stall));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

bind shr_survivor_store shr_survivor_store_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .out_valid(out_valid),
  .out_ovf(out_ovf), .out_done(out_done), .line_we(line_we), .cnt(cnt)
);

// File: tb/shr_survivor_store_tb.sv
module shr_survivor_store_tb;
  localparam int K = 4, M = 4, DEPTH = 4, RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid = 1'b0;
  logic [K*RW-1:0] step_par = '0;
  logic [K-1:0] step_bit = '0;
  logic step_last = 1'b0;
  logic [RW-1:0] step_best = '0;
  logic stall, out_valid, out_ovf, out_done;
  logic [M-1:0] out_bits;

  always #2.5 clk = ~clk;

  shr_survivor_store #(.K(K), .M(M), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_par(step_par),
    .step_bit(step_bit), .step_last(step_last), .step_best(step_best),
    .stall(stall), .out_valid(out_valid), .out_bits(out_bits),
    .out_ovf(out_ovf), .out_done(out_done)
  );

  // {last, best[1:0], par[7:0], bits[3:0]}
  localparam logic [14:0] S1 [24] = '{
    {1'b0,2'd0,8'h00,4'h8}, {1'b0,2'd0,8'h1B,4'h1}, {1'b0,2'd0,8'hE4,4'h0}, {1'b0,2'd0,8'hE4,4'h1},
    {1'b0,2'd0,8'h00,4'h0}, {1'b0,2'd0,8'h1B,4'h0}, {1'b0,2'd0,8'hE4,4'h1}, {1'b0,2'd0,8'hE4,4'h1},
    {1'b0,2'd0,8'h00,4'h8}, {1'b0,2'd0,8'h1B,4'h0}, {1'b0,2'd0,8'hE4,4'h0}, {1'b0,2'd0,8'hE4,4'h0},
    {1'b0,2'd0,8'h00,4'h0}, {1'b0,2'd0,8'h1B,4'h1}, {1'b0,2'd0,8'hE4,4'h0}, {1'b0,2'd0,8'hE4,4'h0},
    {1'b0,2'd0,8'h00,4'h8}, {1'b0,2'd0,8'h1B,4'h1}, {1'b0,2'd0,8'hE4,4'h1}, {1'b0,2'd0,8'hE4,4'h1},
    {1'b0,2'd0,8'h00,4'h2}, {1'b0,2'd0,8'h1B,4'h0}, {1'b0,2'd0,8'hE4,4'h4}, {1'b1,2'd2,8'hE4,4'h0}
  };
  localparam logic [3:0] S1_EXP [6] = '{4'hD, 4'h3, 4'h8, 4'h4, 4'hF, 4'hA};

  int checks = 0, errors = 0;
  int nout = 0, ndone = 0;
  logic [M-1:0] obits [32];
  logic oovf [32];
  logic odone [32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] gen(input int r, input int l);
    return 4'((r * 7 + l * 11 + 3) & 15);
  endfunction

  // Word of rank i when all levels after the first keep rank order.
  function automatic logic [3:0] word_id(input int r, input int i);
    return {gen(r, 0)[i], gen(r, 1)[i], gen(r, 2)[i], gen(r, 3)[i]};
  endfunction

  always @(negedge clk) begin
    if (!rst && out_valid && nout < 32) begin
      obits[nout] = out_bits;
      oovf[nout]  = out_ovf;
      odone[nout] = out_done;
      nout++;
      if (out_done) ndone++;
    end
  end

  task automatic do_step(input logic [7:0] par, input logic [3:0] b,
                         input logic last, input logic [1:0] bst);
    @(negedge clk);
    while (stall) @(negedge clk);
    step_valid = 1'b1; step_par = par; step_bit = b;
    step_last = last; step_best = bst;
    @(negedge clk);
    step_valid = 1'b0; step_last = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (stall) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 2000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R8 out_valid", out_valid, 0);
    chk(!out_ovf,   "R8 out_ovf",   out_ovf,   0);
    chk(!out_done,  "R8 out_done",  out_done,  0);
    chk(!stall,     "R8 stall",     stall,     0);

    // Scenario 1: merges every realization, reversal inside (R1, R3, R6)
    for (int s = 0; s < 24; s++) begin
      do_step(S1[s][11:4], S1[s][3:0], S1[s][14], S1[s][13:12]);
      if (s == 3) chk(stall == 1'b1, "R7 stall after line", stall, 1);
    end
    wait (ndone == 1);
    wait_idle();
    chk(nout == 6, "R3 word count", nout, 6);
    chk(!stall, "R7 stall released", stall, 0);
    for (int i = 0; i < 6; i++) begin
      chk(obits[i] == S1_EXP[i], "R1 R3 merged word", obits[i], S1_EXP[i]);
      chk(!oovf[i], "R3 no overflow", oovf[i], 0);
      chk(odone[i] == (i == 5), "R6 done position", odone[i], i == 5);
    end

    // Scenario 2: identity ancestry, never merges (R4, R5, R6)
    nout = 0;
    for (int r = 0; r < 6; r++) begin
      for (int l = 0; l < 4; l++)
        do_step(8'hE4, gen(r, l), (r == 5 && l == 3), 2'd2);
      if (r == 2) begin
        wait_idle();
        chk(nout == 0, "R4 nothing released", nout, 0);
      end
    end
    wait (ndone == 2);
    wait_idle();
    chk(nout == 6, "R5 word count", nout, 6);
    for (int i = 0; i < 2; i++) begin
      chk(obits[i] == word_id(i, 0), "R5 forced word rank0", obits[i], word_id(i, 0));
      chk(oovf[i] == 1'b1, "R5 overflow flag", oovf[i], 1);
    end
    for (int i = 2; i < 6; i++) begin
      chk(obits[i] == word_id(i, 2), "R6 traceback word", obits[i], word_id(i, 2));
      chk(!oovf[i], "R6 no overflow", oovf[i], 0);
    end
    chk(odone[5], "R6 done on last", odone[5], 1);

    // Scenario 3: rotating ancestry across lines (R2, R4, R6)
    nout = 0;
    for (int r = 0; r < 3; r++)
      for (int l = 0; l < 4; l++)
        do_step(l == 0 ? 8'h39 : 8'hE4, gen(r + 10, l), (r == 2 && l == 3), 2'd1);
    wait (ndone == 3);
    wait_idle();
    chk(nout == 3, "R4 R2 word count", nout, 3);
    for (int i = 0; i < 3; i++) begin
      chk(obits[i] == word_id(i + 10, 3 - i), "R2 chain word", obits[i], word_id(i + 10, 3 - i));
      chk(odone[i] == (i == 2), "R6 done position", odone[i], i == 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule